// File: doc/BRIEF.md
# PLL Divider Search Engine

This block picks the input divider N and the even feedback multiplier M of a PLL so that the resulting VCO frequency lands as close as possible to the bit rate that a serial display lane must carry. The host presents the pixel clock, the number of lanes, a pixel-format code and the reference frequency, all as plain integers in hertz or counts, and pulses `start`. The block first derives the lane bit rate. That rate includes a 10/8 margin over the raw pixel bandwidth. The block then walks every legal N in ascending order, one candidate at a time, and keeps the best one.

All divisions go through one shared 64-bit restoring divider, which takes one quotient bit per cycle. A search therefore lasts a few hundred cycles per candidate N. Inputs that cannot be used, and a target that is already too fast, are rejected before any candidate is tried. When the search ends, `done` pulses for one cycle. `ok` or `err` then reports the outcome, and the chosen N, M and VCO frequency stay on the outputs until the next accepted `start`.

Top module: `pll_div_search`

## Requirements
- R1: Format codes map to bits per pixel as 0 -> 24, 1 -> 24, 2 -> 18, 3 -> 16. Any code from 4 to 7 ends the request with `err`.
- R2: The target rate is floor(floor(floor(pclk/lanes) x bpp) / 8) x 10, computed step by step with integer division. A lane count of 0 or a reference of 0 ends the request with `err`.
- R3: A target of 1,500,000,000 or more ends the request with `err`, and no candidate is chosen.
- R4: Candidate N runs from ceil(fref/40 MHz) to floor(fref/5 MHz), with both ends included. An empty range is a failure.
- R5: For each N, M is floor(target x N / fref), plus 1 if that value is odd. Candidates with M below 6 or above 512 are skipped.
- R6: A candidate is kept only if fref x M / N (floored) lies between 80,000,000 and 1,500,000,000, with both ends included.
- R7: A candidate becomes the best only if its absolute error is strictly smaller than the best so far. The starting bound is 1,500,000,000, so on a tie the lowest N wins.
- R8: When no candidate qualifies, the request ends with `err`, and `best_n`, `best_m` and `vco_hz` read 0.
- R9: `done` is a one-cycle pulse, and exactly one of `ok` and `err` is high with it. A rejected input raises `done` one cycle after `start`. The results hold until the next accepted `start`. A `start` that arrives while `busy` is high is ignored.
- R10: After reset, `busy`, `done`, `ok`, `err`, `best_n`, `best_m` and `vco_hz` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Begin a search with the present inputs (ignored while busy) |
| pclk_hz | input | 32 | Pixel clock in Hz |
| lanes | input | 4 | Number of data lanes |
| fmt | input | 3 | Pixel-format code |
| fref_hz | input | 32 | PLL reference frequency in Hz |
| busy | output | 1 | Search in progress |
| done | output | 1 | One-cycle end-of-request pulse |
| ok | output | 1 | Last request found a divider pair |
| err | output | 1 | Last request was rejected or found nothing |
| best_n | output | 12 | Chosen input divider |
| best_m | output | 10 | Chosen feedback multiplier |
| vco_hz | output | 32 | Resulting VCO frequency in Hz |

## Verification
A rejected input is due exactly one cycle after `start`, so the bench samples `done` and `err` at the falling edge that follows that first rising edge, and checks that `done` is low again one cycle later. A full search lasts a variable number of divider passes, so the bench polls `done` at falling edges and reads `ok`, N, M and the VCO frequency in the same half-cycle in which the pulse is seen. A few cycles later it reads them again to confirm that they hold. For the busy case, a second `start` is driven twenty cycles into a search, and the bench confirms that the result still belongs to the first request.

// File: rtl/pllsrch_pkg.sv
package pllsrch_pkg;

  typedef enum logic [3:0] {
    S_IDLE, S_WLANE, S_TGT, S_WNMIN, S_WNMAX, S_WM, S_WF, S_NEXT, S_FIN
  } srch_state_t;

  // Bits per pixel for a format code; 0 marks an unusable code.
  function automatic logic [4:0] bpp_of(input logic [2:0] code);
    case (code)
      3'd0, 3'd1: return 5'd24;
      3'd2:       return 5'd18;
      3'd3:       return 5'd16;
      default:    return 5'd0;
    endcase
  endfunction

  // Round an odd multiplier up to the next even value.
  function automatic logic [63:0] make_even(input logic [63:0] v);
    return v + {63'd0, v[0]};
  endfunction

  function automatic logic [63:0] abs_diff(input logic [63:0] a, input logic [63:0] b);
    return (a > b) ? (a - b) : (b - a);
  endfunction

  // Target lane rate from the first quotient: floor(q*bpp/8)*10.
  function automatic logic [63:0] lane_rate(input logic [63:0] q, input logic [4:0] bpp);
    logic [63:0] prod;
    prod = q * {59'd0, bpp};
    return (prod >> 3) * 64'd10;
  endfunction

endpackage

// File: rtl/pllsrch_div.sv
module pllsrch_div #(
  parameter int A_W = 64,
  parameter int B_W = 32
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           go,
  input  logic [A_W-1:0] a,
  input  logic [B_W-1:0] b,
  output logic           rdy,
  output logic [A_W-1:0] quo
);
  localparam int CNT_W = $clog2(A_W + 1);

  logic [CNT_W-1:0] cnt;
  logic             run;
  logic [A_W-1:0]   q;
  logic [B_W-1:0]   r;
  logic [A_W-1:0]   a_hold;
  logic [B_W-1:0]   b_hold;
  logic [B_W:0]     shifted;
  logic [B_W-1:0]   r_nxt;
  logic             q_bit;

  always_comb begin
    shifted = {r, q[A_W-1]};
    if (shifted >= {1'b0, b_hold}) begin
      r_nxt = B_W'(shifted - {1'b0, b_hold});
      q_bit = 1'b1;
    end else begin
      r_nxt = shifted[B_W-1:0];
      q_bit = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt <= '0; run <= 1'b0; rdy <= 1'b0;
      q <= '0; r <= '0; a_hold <= '0; b_hold <= '0;
    end else begin
      rdy <= 1'b0;
      if (go) begin
        q <= a; r <= '0; a_hold <= a; b_hold <= b;
        cnt <= CNT_W'(A_W); run <= 1'b1;
      end else if (run) begin
        r   <= r_nxt;
        q   <= {q[A_W-2:0], q_bit};
        cnt <= cnt - 1'b1;
        if (cnt == CNT_W'(1)) begin
          run <= 1'b0;
          rdy <= 1'b1;
        end
      end
    end
  end

  assign quo = q;

  // R2
  div_exact_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rdy && b_hold != '0) |->
      ((96'(q) * 96'(b_hold) + 96'(r)) == 96'(a_hold) && r < b_hold));

endmodule

// File: rtl/pll_div_search.sv
module pll_div_search
  import pllsrch_pkg::*;
#(
  parameter int          N_W     = 12,
  parameter int          M_W     = 10,
  parameter int unsigned RATE_MAX = 1500000000,
  parameter int unsigned VCO_MIN = 80000000,
  parameter int unsigned PFD_MAX = 40000000,
  parameter int unsigned PFD_MIN = 5000000,
  parameter int unsigned M_LO    = 6,
  parameter int unsigned M_HI    = 512
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           start,
  input  logic [31:0]    pclk_hz,
  input  logic [3:0]     lanes,
  input  logic [2:0]     fmt,
  input  logic [31:0]    fref_hz,
  output logic           busy,
  output logic           done,
  output logic           ok,
  output logic           err,
  output logic [N_W-1:0] best_n,
  output logic [M_W-1:0] best_m,
  output logic [31:0]    vco_hz
);
  localparam logic [63:0] RATE_MAX64 = 64'(RATE_MAX);
  localparam logic [63:0] VCO_MIN64  = 64'(VCO_MIN);
  localparam logic [63:0] PFD_MAX64  = 64'(PFD_MAX);
  localparam logic [63:0] M_LO64     = 64'(M_LO);
  localparam logic [63:0] M_HI64     = 64'(M_HI);

  srch_state_t    state;
  logic [63:0]    target;
  logic [31:0]    fref_q;
  logic [4:0]     bpp_q;
  logic [N_W-1:0] n_cur, n_last;
  logic [M_W-1:0] m_cur;
  logic [63:0]    best_err;
  logic           found;

  logic           div_go, div_rdy;
  logic [63:0]    div_a, div_q;
  logic [31:0]    div_b;

  pllsrch_div #(.A_W(64), .B_W(32)) u_div (
    .clk(clk), .rst_n(rst_n), .go(div_go), .a(div_a), .b(div_b),
    .rdy(div_rdy), .quo(div_q)
  );

  // Named events used by the datapath and the assertions.
  logic [4:0]  bpp_in;
  logic        bad_input;
  logic [63:0] m_even, err_now;
  logic        m_ok, f_ok, better;

  assign bpp_in    = bpp_of(fmt);
  assign bad_input = (bpp_in == 5'd0) || (lanes == 4'd0) || (fref_hz == 32'd0);
  assign m_even    = make_even(div_q);
  assign m_ok      = (m_even >= M_LO64) && (m_even <= M_HI64);
  assign f_ok      = (div_q >= VCO_MIN64) && (div_q <= RATE_MAX64);
  assign err_now   = abs_diff(target, div_q);
  assign better    = f_ok && (err_now < best_err);
  assign busy      = (state != S_IDLE);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state <= S_IDLE; target <= '0; fref_q <= '0; bpp_q <= '0;
      n_cur <= '0; n_last <= '0; m_cur <= '0; best_err <= '0; found <= 1'b0;
      div_go <= 1'b0; div_a <= '0; div_b <= '0;
      done <= 1'b0; ok <= 1'b0; err <= 1'b0;
      best_n <= '0; best_m <= '0; vco_hz <= '0;
    end else begin
      div_go <= 1'b0;
      done   <= 1'b0;
      unique case (state)
        S_IDLE: if (start) begin
          ok <= 1'b0; err <= 1'b0; found <= 1'b0;
          best_n <= '0; best_m <= '0; vco_hz <= '0;
          best_err <= RATE_MAX64;
          fref_q <= fref_hz; bpp_q <= bpp_in;
          if (bad_input) begin
            done <= 1'b1; err <= 1'b1;
          end else begin
            div_go <= 1'b1; div_a <= 64'(pclk_hz); div_b <= 32'(lanes);
            state <= S_WLANE;
          end
        end
        S_WLANE: if (div_rdy) begin
          target <= lane_rate(div_q, bpp_q);
          state  <= S_TGT;
        end
        S_TGT: begin
          if (target >= RATE_MAX64) state <= S_FIN;
          else begin
            div_go <= 1'b1; div_a <= 64'(fref_q) + PFD_MAX64 - 64'd1;
            div_b  <= PFD_MAX; state <= S_WNMIN;
          end
        end
        S_WNMIN: if (div_rdy) begin
          n_cur  <= N_W'(div_q);
          div_go <= 1'b1; div_a <= 64'(fref_q); div_b <= PFD_MIN;
          state  <= S_WNMAX;
        end
        S_WNMAX: if (div_rdy) begin
          n_last <= N_W'(div_q);
          if (div_q < 64'(n_cur)) state <= S_FIN;
          else begin
            div_go <= 1'b1; div_a <= target * 64'(n_cur); div_b <= fref_q;
            state  <= S_WM;
          end
        end
        S_WM: if (div_rdy) begin
          if (m_ok) begin
            m_cur  <= M_W'(m_even);
            div_go <= 1'b1; div_a <= m_even * 64'(fref_q); div_b <= 32'(n_cur);
            state  <= S_WF;
          end else state <= S_NEXT;
        end
        S_WF: if (div_rdy) begin
          if (better) begin
            best_err <= err_now; best_n <= n_cur; best_m <= m_cur;
            vco_hz <= 32'(div_q); found <= 1'b1;
          end
          state <= S_NEXT;
        end
        S_NEXT: begin
          if (n_cur == n_last) state <= S_FIN;
          else begin
            n_cur  <= n_cur + 1'b1;
            div_go <= 1'b1; div_a <= target * 64'(n_cur + 1'b1); div_b <= fref_q;
            state  <= S_WM;
          end
        end
        S_FIN: begin
          done <= 1'b1; ok <= found; err <= !found;
          state <= S_IDLE;
        end
        default: state <= S_IDLE;
      endcase
    end
  end

  // R9
  done_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (ok ^ err) && !busy);

  // R9
  start_only_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> $past(start));

  // R5
  m_even_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ok |-> (!best_m[0] && 64'(best_m) >= M_LO64 && 64'(best_m) <= M_HI64));

  // R6
  vco_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ok |-> (64'(vco_hz) >= VCO_MIN64 && 64'(vco_hz) <= RATE_MAX64));

  // R7
  err_shrink_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (state != S_IDLE && $past(state) != S_IDLE) |-> best_err <= $past(best_err));

  // R4
  n_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (state == S_WM) |-> (n_cur <= n_last && 64'(n_cur) * 64'(PFD_MIN) <= 64'(fref_q)));

endmodule

// File: tb/pll_div_search_bench.sv
module pll_div_search_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start = 1'b0;
  logic [31:0] pclk_hz = '0;
  logic [3:0]  lanes = '0;
  logic [2:0]  fmt = '0;
  logic [31:0] fref_hz = '0;
  logic        busy, done, ok, err;
  logic [11:0] best_n;
  logic [9:0]  best_m;
  logic [31:0] vco_hz;

  int checks = 0;
  int errors = 0;
  int cyc = 0;

  always #2 clk = ~clk;

  pll_div_search u_pll_div_search (
    .clk(clk), .rst_n(rst_n), .start(start), .pclk_hz(pclk_hz), .lanes(lanes),
    .fmt(fmt), .fref_hz(fref_hz), .busy(busy), .done(done), .ok(ok), .err(err),
    .best_n(best_n), .best_m(best_m), .vco_hz(vco_hz)
  );

  typedef struct packed {
    logic [31:0] pclk;
    logic [3:0]  ln;
    logic [2:0]  fm;
    logic [31:0] fref;
    logic        xok;
    logic [11:0] xn;
    logic [9:0]  xm;
    logic [31:0] xvco;
  } vec_t;

  localparam int NV = 11;
  localparam vec_t TBL [NV] = '{
    '{32'd148500000, 4'd4, 3'd0, 32'd24000000, 1'b1, 12'd4, 10'd186, 32'd1116000000}, // R1 R5
    '{32'd148500000, 4'd4, 3'd1, 32'd24000000, 1'b1, 12'd4, 10'd186, 32'd1116000000}, // R1
    '{32'd65000000,  4'd2, 3'd3, 32'd24000000, 1'b1, 12'd2, 10'd54,  32'd648000000},  // R7 tie
    '{32'd100000000, 4'd2, 3'd2, 32'd24000000, 1'b1, 12'd2, 10'd94,  32'd1128000000}, // R1 R7
    '{32'd4000000,   4'd1, 3'd3, 32'd24000000, 1'b1, 12'd3, 10'd10,  32'd80000000},   // R5 R6
    '{32'd4000000,   4'd1, 3'd3, 32'd45000000, 1'b1, 12'd9, 10'd16,  32'd80000000},   // R4
    '{32'd74850000,  4'd1, 3'd3, 32'd24000000, 1'b1, 12'd4, 10'd250, 32'd1500000000}, // R6
    '{32'd300000000, 4'd1, 3'd0, 32'd24000000, 1'b0, 12'd0, 10'd0,   32'd0},          // R3
    '{32'd150000000, 4'd3, 3'd0, 32'd24000000, 1'b0, 12'd0, 10'd0,   32'd0},          // R3 edge
    '{32'd2000000,   4'd4, 3'd3, 32'd24000000, 1'b0, 12'd0, 10'd0,   32'd0},          // R8
    '{32'd4000000,   4'd1, 3'd3, 32'd4000000,  1'b0, 12'd0, 10'd0,   32'd0}           // R4 R8
  };

  task automatic check(input string tag, input longint unsigned act, input longint unsigned exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic kick(input logic [31:0] p, input logic [3:0] l, input logic [2:0] f,
                      input logic [31:0] r);
    @(negedge clk);
    pclk_hz = p; lanes = l; fmt = f; fref_hz = r; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
  endtask

  task automatic wait_done();
    for (int i = 0; i < 20000; i++) begin
      if (done) return;
      @(negedge clk);
    end
    check("R9 done never seen", 0, 1);
  endtask

  // Independent restatement of the search, in plain integer arithmetic.
  task automatic model(input longint unsigned p, input longint unsigned l,
                       input int f, input longint unsigned r,
                       output bit xok, output longint unsigned xn,
                       output longint unsigned xm, output longint unsigned xv);
    longint unsigned bpp, t, best, mm, fr, d;
    xok = 0; xn = 0; xm = 0; xv = 0;
    bpp = (f <= 1) ? 24 : (f == 2) ? 18 : (f == 3) ? 16 : 0;
    if (bpp == 0 || l == 0 || r == 0) return;
    t = (p / l) * bpp / 8 * 10;
    if (t >= 1500000000) return;
    best = 1500000000;
    for (longint unsigned nn = (r + 39999999) / 40000000; nn <= r / 5000000; nn++) begin
      mm = t * nn / r;
      if (mm % 2 == 1) mm++;
      if (mm < 6 || mm > 512) continue;
      fr = mm * r / nn;
      if (fr < 80000000 || fr > 1500000000) continue;
      d = (t > fr) ? t - fr : fr - t;
      if (d < best) begin
        best = d; xok = 1; xn = nn; xm = mm; xv = fr;
      end
    end
  endtask

  initial begin
    forever begin
      @(posedge clk);
      cyc++;
      if (cyc > 150000) begin
        check("R9 watchdog cycles", cyc, 150000);
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
      end
    end
  end

  initial begin
    bit mok; longint unsigned mn, mm, mv;
    logic [11:0] hn; logic [9:0] hm; logic [31:0] hv;
    repeat (3) @(negedge clk);
    // R10 reset state
    check("R10 busy", busy, 0); check("R10 done", done, 0);
    check("R10 ok", ok, 0);     check("R10 err", err, 0);
    check("R10 n", best_n, 0);  check("R10 m", best_m, 0);
    check("R10 vco", vco_hz, 0);
    rst_n = 1'b1;

    for (int k = 0; k < NV; k++) begin
      kick(TBL[k].pclk, TBL[k].ln, TBL[k].fm, TBL[k].fref);
      wait_done();
      check($sformatf("R7 row %0d ok", k), ok, TBL[k].xok);
      check($sformatf("R9 row %0d err", k), err, !TBL[k].xok);
      check($sformatf("R7 row %0d n", k), best_n, TBL[k].xn);
      check($sformatf("R5 row %0d m", k), best_m, TBL[k].xm);
      check($sformatf("R6 row %0d vco", k), vco_hz, TBL[k].xvco);
    end

    // R9 hold and single-cycle pulse after the last search
    hn = best_n; hm = best_m; hv = vco_hz;
    kick(32'd148500000, 4'd4, 3'd0, 32'd24000000);
    wait_done();
    hn = best_n; hm = best_m; hv = vco_hz;
    @(negedge clk);
    check("R9 done pulse width", done, 0);
    repeat (5) @(negedge clk);
    check("R9 hold n", best_n, hn); check("R9 hold m", best_m, hm);
    check("R9 hold vco", vco_hz, hv); check("R9 hold ok", ok, 1);

    // R1 bad format: done one cycle after start
    kick(32'd148500000, 4'd4, 3'd5, 32'd24000000);
    check("R1 bad fmt done", done, 1); check("R1 bad fmt err", err, 1);
    check("R8 bad fmt n", best_n, 0);
    @(negedge clk);
    check("R9 err pulse width", done, 0);

    // R2 zero lanes, zero reference
    kick(32'd148500000, 4'd0, 3'd0, 32'd24000000);
    check("R2 zero lanes err", err & done, 1);
    kick(32'd148500000, 4'd4, 3'd0, 32'd0);
    check("R2 zero fref err", err & done, 1);

    // R9 start during busy is ignored
    kick(32'd65000000, 4'd2, 3'd3, 32'd24000000);
    repeat (20) @(negedge clk);
    pclk_hz = 32'd300000000; lanes = 4'd1; fmt = 3'd7; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    wait_done();
    check("R9 busy start ok", ok, 1); check("R9 busy start n", best_n, 2);
    check("R9 busy start vco", vco_hz, 648000000);

    // R4 wider ranges against the bench model
    for (int k = 0; k < 3; k++) begin
      logic [31:0] pp, rr; logic [3:0] ll; logic [2:0] ff;
      pp = (k == 0) ? 32'd148500000 : (k == 1) ? 32'd74250000 : 32'd33000000;
      ll = (k == 0) ? 4'd4 : (k == 1) ? 4'd3 : 4'd1;
      ff = (k == 0) ? 3'd2 : (k == 1) ? 3'd0 : 3'd3;
      rr = (k == 0) ? 32'd100000000 : (k == 1) ? 32'd27000000 : 32'd19200000;
      model(pp, ll, int'(ff), rr, mok, mn, mm, mv);
      kick(pp, ll, ff, rr);
      wait_done();
      check($sformatf("R4 sweep %0d ok", k), ok, mok);
      check($sformatf("R4 sweep %0d n", k), best_n, mn);
      check($sformatf("R5 sweep %0d m", k), best_m, mm);
      check($sformatf("R6 sweep %0d vco", k), vco_hz, mv);
    end

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule